// File: doc/BRIEF.md
# LCD Common Scan Sequencer

This block sequences the row scan of a 128-column dot-matrix panel that has up to 32 graphic commons and one icon common. Each scan step is advanced by a single-cycle enable that stands in for the line clock. For each step the block names the common being driven and the display RAM row that the surrounding logic must present. It then registers one vector of segment on/off levels for that common.

Software settings arrive as static level inputs. These settings are the start-line offset, the duty (full: 32 commons plus icon; reduced: 16 commons plus icon), the interleaved common order, the display enable, the all-lit mode, the reverse mode, the column direction and the icon-only mode. The display enable and all-lit settings together select one of four panel states: normal, all lit, blank or power save. In power save the scan freezes and every output is forced off. A status byte reports the settings.

The RAM itself lives outside the block. It must return `row_bits_i` for `row_idx_o` and `icon_bits_i` for the icon row within the same cycle, with no register in the read path.

Top module: `lcd_scan_seq`

## Requirements
- R1: While `rst_ni` is low, `seg_o` is all zeros, `com_valid_o` is 0 and the scan position is step 0. In the first cycle after reset, `com_idx_o` is 0.
- R2: Each cycle with `step_en_i` high and no power save moves the scan to the next step. At full duty (`full_duty_i`=1) the steps run 0 to 32; at reduced duty they run 0 to 16. The last step is the icon step, shown as `com_idx_o`=32, and after it the scan returns to step 0. If the scan is already at or beyond the reduced-duty icon step when the duty drops, the next advance returns it to 0. `com_idx_o`, `seg_o` and `com_valid_o` follow the step register one clock later.
- R3: At full duty with `alt_order_i`=1, graphic step 2k drives common k and step 2k+1 drives common k+16. Otherwise, and always at reduced duty, step s drives common s.
- R4: On a graphic step, `row_idx_o` = (`start_line_i` + common index) mod 64, and `icon_req_o`=0. On the icon step, `icon_req_o`=1 and the segment data comes from `icon_bits_i`.
- R5: In normal display mode, a fetched bit of 1 lights its segment. With `reverse_i`=1, a fetched bit of 0 lights it.
- R6: With `col_rev_i`=0, `seg_o[j]` is taken from column bit j. With `col_rev_i`=1, `seg_o[j]` is taken from column bit 127-j.
- R7: With `disp_on_i`=0 and `all_lit_i`=0, `seg_o` is all zeros while the commons keep scanning and `com_valid_o` stays 1.
- R8: With `disp_on_i`=1 and `all_lit_i`=1, `seg_o` is all ones, whatever the data, the reverse setting and the icon-only setting.
- R9: With `disp_on_i`=0 and `all_lit_i`=1 (power save), `seg_o` is all zeros and `com_valid_o` is 0. Enables are ignored, and the scan resumes from the same step when power save ends.
- R10: With `icon_only_i`=1, graphic steps give all-zero segments and the icon step shows the icon data.
- R11: `status_o` bit 7 = 0 (busy), bit 6 = NOT `col_rev_i`, bit 5 = NOT `disp_on_i`, bit 4 = 0 (reset), bit 3 = power save, bit 2 = `icon_only_i`, bit 1 = `reverse_i`, bit 0 = `all_lit_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_en_i | input | 1 | Advance the scan by one step |
| full_duty_i | input | 1 | 1: 32 graphic commons, 0: 16 |
| alt_order_i | input | 1 | Interleave the lower and upper halves at full duty |
| start_line_i | input | 6 | RAM row shown on common 0 |
| disp_on_i | input | 1 | Display enable |
| all_lit_i | input | 1 | All-lit mode; with display off, selects power save |
| reverse_i | input | 1 | Invert the pixel polarity |
| col_rev_i | input | 1 | Reverse the column-to-segment order |
| icon_only_i | input | 1 | Blank the graphic commons |
| row_bits_i | input | 128 | RAM row addressed by row_idx_o |
| icon_bits_i | input | 128 | Icon row, one bit per column |
| row_idx_o | output | 6 | RAM row to fetch |
| icon_req_o | output | 1 | The current step is the icon step |
| com_idx_o | output | 6 | Active common, 32 for the icon common |
| com_valid_o | output | 1 | Common drive active |
| seg_o | output | 128 | Segment on/off levels |
| status_o | output | 8 | Status byte |

## Verification
`row_idx_o`, `icon_req_o` and `status_o` are combinational. They are due in the same cycle as the step register or setting that drives them. `com_idx_o`, `seg_o` and `com_valid_o` are due one clock after the step register, so they arrive two edges after the last enabled edge. The bench therefore drops the enable at a falling edge, lets exactly one more rising edge pass, and samples at the following falling edge. A change of setting alone is sampled after one rising edge.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    DM_NORMAL  = 2'd0,
    DM_ALL_LIT = 2'd1,
    DM_BLANK   = 2'd2,
    DM_PSAVE   = 2'd3
  } disp_mode_e;

  function automatic disp_mode_e decode_mode(input logic on, input logic lit);
    case ({on, lit})
      2'b10:   return DM_NORMAL;
      2'b11:   return DM_ALL_LIT;
      2'b00:   return DM_BLANK;
      default: return DM_PSAVE;
    endcase
  endfunction
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int COMS  = 32,
  parameter int ROWS  = 64,
  localparam int STEP_W = $clog2(COMS + 1),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_en_i,
  input  logic              psave_i,
  input  logic              full_duty_i,
  input  logic              alt_order_i,
  input  logic [ROW_W-1:0]  start_line_i,
  output logic [STEP_W-1:0] com_o,
  output logic              is_icon_o,
  output logic [ROW_W-1:0]  row_o
);
  localparam int HALF = COMS / 2;

  logic [STEP_W-1:0] step_q, last;

  assign last = full_duty_i ? STEP_W'(COMS) : STEP_W'(HALF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   step_q <= '0;
    else if (step_en_i && !psave_i) step_q <= (step_q >= last) ? '0 : step_q + 1'b1;
  end

  always_comb begin
    is_icon_o = (step_q >= last);
    if (is_icon_o)                      com_o = STEP_W'(COMS);
    else if (full_duty_i && alt_order_i) com_o = (step_q >> 1) + (step_q[0] ? STEP_W'(HALF) : '0);
    else                                 com_o = step_q;
    row_o = ROW_W'((32'(start_line_i) + 32'(com_o)) % ROWS);
  end

  // R2
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= STEP_W'(COMS));
  // R2
  step_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !psave_i && step_q < last) |=> step_q == $past(step_q) + 1'b1);
  // R2
  step_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !psave_i && step_q >= last) |=> step_q == '0);
  // R9
  psave_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psave_i |=> $stable(step_q));
endmodule

// File: rtl/lcd_seg_fmt.sv
module lcd_seg_fmt
  import lcd_scan_pkg::*;
#(
  parameter int COLS = 128
) (
  input  disp_mode_e       mode_i,
  input  logic             is_icon_i,
  input  logic             icon_only_i,
  input  logic             reverse_i,
  input  logic             col_rev_i,
  input  logic [COLS-1:0]  row_bits_i,
  input  logic [COLS-1:0]  icon_bits_i,
  output logic [COLS-1:0]  seg_o
);
  logic [COLS-1:0] pol, ordered;

  assign pol = (is_icon_i ? icon_bits_i : row_bits_i) ^ {COLS{reverse_i}};

  for (genvar j = 0; j < COLS; j++) begin : g_col
    assign ordered[j] = col_rev_i ? pol[COLS-1-j] : pol[j];
  end

  always_comb begin
    case (mode_i)
      DM_ALL_LIT: seg_o = '1;
      DM_NORMAL:  seg_o = (icon_only_i && !is_icon_i) ? '0 : ordered;
      default:    seg_o = '0;
    endcase
  end
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int COLS = 128,
  parameter int COMS = 32,
  parameter int ROWS = 64,
  localparam int COM_W = $clog2(COMS + 1),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_en_i,
  input  logic             full_duty_i,
  input  logic             alt_order_i,
  input  logic [ROW_W-1:0] start_line_i,
  input  logic             disp_on_i,
  input  logic             all_lit_i,
  input  logic             reverse_i,
  input  logic             col_rev_i,
  input  logic             icon_only_i,
  input  logic [COLS-1:0]  row_bits_i,
  input  logic [COLS-1:0]  icon_bits_i,
  output logic [ROW_W-1:0] row_idx_o,
  output logic             icon_req_o,
  output logic [COM_W-1:0] com_idx_o,
  output logic             com_valid_o,
  output logic [COLS-1:0]  seg_o,
  output logic [7:0]       status_o
);
  disp_mode_e       mode;
  logic             psave, is_icon;
  logic [COM_W-1:0] com;
  logic [COLS-1:0]  seg_d;

  assign mode  = decode_mode(disp_on_i, all_lit_i);
  assign psave = (mode == DM_PSAVE);

  lcd_scan_ctrl #(.COMS(COMS), .ROWS(ROWS)) u_ctrl (
    .clk_i, .rst_ni, .step_en_i,
    .psave_i(psave), .full_duty_i, .alt_order_i, .start_line_i,
    .com_o(com), .is_icon_o(is_icon), .row_o(row_idx_o)
  );

  lcd_seg_fmt #(.COLS(COLS)) u_fmt (
    .mode_i(mode), .is_icon_i(is_icon), .icon_only_i, .reverse_i, .col_rev_i,
    .row_bits_i, .icon_bits_i, .seg_o(seg_d)
  );

  assign icon_req_o = is_icon;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_o       <= '0;
      com_idx_o   <= '0;
      com_valid_o <= 1'b0;
    end else begin
      seg_o       <= seg_d;
      com_idx_o   <= com;
      com_valid_o <= !psave;
    end
  end

  assign status_o = {1'b0, ~col_rev_i, ~disp_on_i, 1'b0, psave, icon_only_i, reverse_i, all_lit_i};

  // R9
  psave_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!disp_on_i && all_lit_i)) |-> (seg_o == '0 && !com_valid_o));
  // R8
  all_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(disp_on_i && all_lit_i)) |-> (&seg_o));
  // R7
  blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!disp_on_i && !all_lit_i)) |-> (seg_o == '0 && com_valid_o));
  // R10
  icon_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(disp_on_i && !all_lit_i && icon_only_i && !is_icon)) |-> seg_o == '0);
  // R4
  icon_com_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(is_icon) && com_valid_o) |-> com_idx_o == COM_W'(COMS));
endmodule

// File: tb/sim_lcd_scan_seq.sv
`timescale 1ns/1ps
module sim_lcd_scan_seq;
  logic clk = 0, rst_ni = 0;
  always #4 clk = ~clk;

  logic step_en = 0, full = 1, alt = 0, on = 1, lit = 0, rev = 0, crev = 0, icn = 0;
  logic [5:0] start = 0;
  logic [127:0] row_bits, icon_bits;
  logic [5:0] row_idx, com_idx;
  logic icon_req, com_valid;
  logic [127:0] seg;
  logic [7:0] status;
  int checks = 0, errors = 0;
  bit done = 0;

  lcd_scan_seq u0 (
    .clk_i(clk), .rst_ni, .step_en_i(step_en), .full_duty_i(full), .alt_order_i(alt),
    .start_line_i(start), .disp_on_i(on), .all_lit_i(lit), .reverse_i(rev),
    .col_rev_i(crev), .icon_only_i(icn), .row_bits_i(row_bits), .icon_bits_i(icon_bits),
    .row_idx_o(row_idx), .icon_req_o(icon_req), .com_idx_o(com_idx),
    .com_valid_o(com_valid), .seg_o(seg), .status_o(status)
  );

  // RAM model, no read latency
  function automatic logic [127:0] gpat(input logic [5:0] r);
    return {16{2'b10, r}};
  endfunction
  localparam logic [127:0] IPAT = {32{4'hC}};
  assign row_bits  = gpat(row_idx);
  assign icon_bits = IPAT;

  function automatic logic [127:0] exp_seg(input logic [5:0] r, input logic ic);
    logic [127:0] src, o;
    if (!on) return '0;
    if (lit) return '1;
    if (icn && !ic) return '0;
    src = ic ? IPAT : gpat(r);
    for (int j = 0; j < 128; j++) o[j] = (crev ? src[127-j] : src[j]) ^ rev;
    return o;
  endfunction

  function automatic logic [7:0] exp_status();
    return {1'b0, ~crev, ~on, 1'b0, (!on && lit), icn, rev, lit};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [5:0] adv;
    logic [5:0] st;
    logic full, alt, on, lit, rev, crev, icn;
    logic [5:0] com;
    logic ic;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{6'd0,  6'd0,  1,0,1,0,0,0,0, 6'd0,  0},  // R1 R4
    '{6'd1,  6'd0,  1,0,1,0,0,0,0, 6'd1,  0},  // R2
    '{6'd1,  6'd10, 1,0,1,0,1,0,0, 6'd2,  0},  // R5 reverse
    '{6'd1,  6'd62, 1,0,1,0,0,1,0, 6'd3,  0},  // R4 wrap, R6
    '{6'd1,  6'd0,  1,1,1,0,0,0,0, 6'd2,  0},  // R3 even step
    '{6'd1,  6'd0,  1,1,1,0,0,0,0, 6'd18, 0},  // R3 odd step
    '{6'd1,  6'd0,  1,1,1,1,1,0,1, 6'd3,  0},  // R8
    '{6'd1,  6'd0,  1,0,0,0,0,0,0, 6'd7,  0},  // R7
    '{6'd1,  6'd0,  1,0,1,0,0,0,1, 6'd8,  0},  // R10 graphic
    '{6'd24, 6'd0,  1,0,1,0,0,1,1, 6'd32, 1},  // R10 icon, R2
    '{6'd1,  6'd0,  1,0,1,0,0,0,0, 6'd0,  0},  // R2 wrap
    '{6'd16, 6'd0,  0,1,1,0,0,0,0, 6'd32, 1},  // R2 reduced icon
    '{6'd1,  6'd0,  0,1,1,0,0,0,0, 6'd0,  0},  // R2 reduced wrap
    '{6'd15, 6'd50, 0,1,1,0,1,1,0, 6'd15, 0},  // R3 ignored at reduced duty
    '{6'd1,  6'd0,  0,0,1,0,0,0,0, 6'd32, 1},  // R2
    '{6'd1,  6'd0,  1,0,1,0,0,0,0, 6'd17, 0}   // R2 duty widened
  };

  task automatic run(input logic [5:0] adv);
    if (adv > 0) begin
      step_en = 1;
      repeat (adv) @(posedge clk);
      @(negedge clk);
      step_en = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_out(input logic [5:0] ecom, input logic ic);
    chk("R2 com_idx", 128'(com_idx), 128'(ecom));
    chk("R4 icon_req", 128'(icon_req), 128'(ic));
    if (!ic) chk("R4 row_idx", 128'(row_idx), 128'((start + ecom) % 64));
    chk("R9 com_valid", 128'(com_valid), 128'(!(!on && lit)));
    chk("R5 R6 seg", seg, exp_seg(row_idx, ic));
    chk("R11 status", 128'(status), 128'(exp_status()));
  endtask

  initial begin
    #5;
    chk("R1 seg in reset", seg, '0);
    chk("R1 com_valid in reset", 128'(com_valid), 128'(0));
    @(negedge clk);
    rst_ni = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      start = VEC[i].st; full = VEC[i].full; alt = VEC[i].alt; on = VEC[i].on;
      lit = VEC[i].lit; rev = VEC[i].rev; crev = VEC[i].crev; icn = VEC[i].icn;
      run(VEC[i].adv);
      check_out(VEC[i].com, VEC[i].ic);
    end
    // R9: power save freezes at step 17 and blanks everything
    @(negedge clk); on = 0; lit = 1;
    run(6'd3);
    chk("R9 seg", seg, '0);
    chk("R9 com_valid", 128'(com_valid), 128'(0));
    chk("R11 psave status", 128'(status), 128'(8'h69));
    @(negedge clk); on = 1; lit = 0;
    run(6'd0);
    check_out(6'd17, 1'b0);  // R9 resume
    // R2: duty drop past the reduced icon step
    @(negedge clk); full = 0;
    run(6'd0);
    check_out(6'd32, 1'b1);
    @(negedge clk);
    run(6'd1);
    check_out(6'd0, 1'b0);
    // R1: reset mid-scan
    @(negedge clk); full = 1; run(6'd5);
    @(negedge clk); rst_ni = 0; #1;
    chk("R1 seg", seg, '0);
    chk("R1 com_valid", 128'(com_valid), 128'(0));
    @(negedge clk); rst_ni = 1;
    run(6'd0);
    chk("R1 com after reset", 128'(com_idx), 128'(0));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule